// File: doc/BRIEF.md
# Instruction prefetch queue controller

This block is the fetch half of a processor whose bus interface and execution side work independently. It keeps a six-entry first-in-first-out buffer of instruction bytes and fills it from memory whenever the execution side leaves the bus free. The execution side reads its next bytes from the buffer head through a valid/ready handshake, so it does not wait on memory.

Each fetch goes to a 20-bit address. That address is a fixed code-segment value shifted left by four bits, added to a 16-bit fetch pointer. The pointer advances by one for every fetch issued. A flush input is used on a jump. It empties the buffer, loads a new fetch pointer and discards any fetch already on the bus. The memory side is a request/acknowledge port with one fetch outstanding at a time.

Top module: `prefetch_queue`

## Requirements
- R1: The buffer returns bytes in the order they were fetched and holds at most DEPTH (default 6) bytes. With the consumer stalled and the bus free, it fills to exactly DEPTH bytes.
- R2: A fetch address is computed modulo 2^20 as (CODE_SEG * 16) + fetch pointer. The pointer increments by one for each fetch issued.
- R3: The fetch pointer wraps from 16'hFFFF to 16'h0000 inside the segment.
- R4: Only one fetch is outstanding at a time. `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is sampled high. The acknowledged byte is taken from `mem_rdata` in that same cycle.
- R5: A new fetch starts only when no fetch is outstanding and fewer than DEPTH bytes are buffered.
- R6: While `bus_busy` is high, no new fetch starts. A fetch already outstanding still completes.
- R7: A `flush` empties the buffer, so `q_valid` is low on the next cycle. It loads `flush_ptr` as the fetch pointer. Data from a fetch in flight at the flush, or acknowledged in the flush cycle, is never placed in the buffer.
- R8: `q_valid` is high whenever the buffer is non-empty, and `q_data` shows the oldest byte. A byte is removed on a cycle where `q_valid` and `q_ready` are both high and `flush` is low.
- R9: A removal and an acknowledged fill in the same cycle are both accepted, and the occupancy is unchanged.
- R10: During reset, `q_valid` and `mem_req` are low. The fetch pointer starts at START_PTR (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy | input | 1 | Execution side is using the bus; blocks new fetches |
| flush | input | 1 | Empty the buffer and redirect fetching |
| flush_ptr | input | 16 | New fetch pointer taken on flush |
| mem_req | output | 1 | Fetch request to memory |
| mem_addr | output | 20 | Byte address of the fetch |
| mem_ack | input | 1 | Memory has returned the requested byte |
| mem_rdata | input | 8 | Returned byte, valid with mem_ack |
| q_valid | output | 1 | Buffer head holds a byte |
| q_data | output | 8 | Byte at the buffer head |
| q_ready | input | 1 | Execution side takes the head byte |

## Verification
Properties check on every cycle the following:
- the occupancy bound;
- request hold and address stability until acknowledge;
- that no fetch starts while full or busy;
- the empty buffer after a flush;
- the unchanged occupancy on a combined pop and fill;
- the pointer wrap.

Only the bench scenarios can show the remaining behaviour. That covers the end-to-end byte order against the address sequence, and the dropping of stale in-flight data after a redirect. It also covers the exact fill level of six, and the byte stream across the 16'hFFFF boundary under random memory latency, stalls and busy periods.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int          DEPTH     = 6,
  parameter logic [15:0] CODE_SEG  = 16'hF000,
  parameter logic [15:0] START_PTR = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_busy,
  input  logic        flush,
  input  logic [15:0] flush_ptr,
  output logic        mem_req,
  output logic [19:0] mem_addr,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        q_valid,
  output logic [7:0]  q_data,
  input  logic        q_ready
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    slots [DEPTH];
  logic [IW-1:0] rd_idx, wr_idx;
  logic [CW-1:0] count;
  logic [15:0]   fetch_ptr;
  logic [19:0]   addr_q;
  logic          pend, drop;

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  wire take  = pend && mem_ack;
  wire push  = take && !drop && !flush;
  wire pop   = q_valid && q_ready && !flush;
  wire issue = !pend && !bus_busy && !flush && (count < CW'(DEPTH));

  assign mem_req  = pend;
  assign mem_addr = addr_q;
  assign q_valid  = (count != '0);
  assign q_data   = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      drop      <= 1'b0;
      addr_q    <= '0;
      fetch_ptr <= START_PTR;
    end else begin
      if (issue) begin
        pend      <= 1'b1;
        addr_q    <= {CODE_SEG, 4'h0} + {4'h0, fetch_ptr};
        fetch_ptr <= fetch_ptr + 16'd1;
      end else if (take) begin
        pend <= 1'b0;
      end
      if (flush) fetch_ptr <= flush_ptr;
      if (flush && pend && !mem_ack) drop <= 1'b1;
      else if (take)                 drop <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= next_idx(wr_idx);
      if (pop)  rd_idx <= next_idx(rd_idx);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_idx] <= mem_rdata;
  end

  a_r1_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r5_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !mem_req) |=> !mem_req);
  a_r6_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !mem_req) |=> !mem_req);
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid);
  a_r9_pop_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && fetch_ptr == 16'hFFFF) |=> (fetch_ptr == 16'h0000));
endmodule

// File: tb/sim_prefetch_queue.sv
`timescale 1ns/1ps
module sim_prefetch_queue;
  localparam logic [15:0] SEG = 16'hF000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_busy = 1'b0, flush = 1'b0, mem_ack = 1'b0, q_ready = 1'b0;
  logic [15:0] flush_ptr = '0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_req, q_valid;
  logic [19:0] mem_addr;
  logic [7:0]  q_data;

  always #2.5 clk = ~clk;

  prefetch_queue #(.DEPTH(6), .CODE_SEG(SEG), .START_PTR(16'h0000)) u0 (
    .clk, .rst_n, .bus_busy, .flush, .flush_ptr, .mem_req, .mem_addr,
    .mem_ack, .mem_rdata, .q_valid, .q_data, .q_ready);

  int tests = 0, fails = 0;
  logic [15:0] exp_fetch = 16'h0000, exp_pop = 16'h0000;
  logic [19:0] held_addr = '0;
  logic prev_req = 1'b0, prev_busy = 1'b0;
  int lat = 1, wait_cnt = 0, force_lat = -1, pops = 0, both = 0;

  function automatic logic [19:0] eaddr(input logic [15:0] p);
    return {SEG, 4'h0} + {4'h0, p};
  endfunction
  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack = 1'b1; mem_rdata = pat(mem_addr); wait_cnt = 0;
        lat = (force_lat >= 0) ? force_lat : int'($urandom % 4);
      end else wait_cnt++;
    end
  end

  task automatic step(input bit b, input bit f, input logic [15:0] fp, input bit r);
    string tag;
    if (mem_req && !prev_req) begin
      chk(mem_addr == eaddr(exp_fetch), "R2 fetch address", mem_addr, eaddr(exp_fetch));
      chk(!prev_busy, "R6 fetch started while busy", 1, 0);
      held_addr = mem_addr;
      exp_fetch = exp_fetch + 16'd1;
    end else if (mem_req && prev_req) begin
      chk(mem_addr == held_addr, "R4 address held", mem_addr, held_addr);
    end
    prev_req = mem_req;
    bus_busy = b; flush = f; flush_ptr = fp; q_ready = r;
    prev_busy = b | f;
    if (f) begin
      exp_fetch = fp; exp_pop = fp;
    end else if (r && q_valid) begin
      tag = mem_ack ? "R9 pop with fill" : "R8 pop data";
      if (mem_ack) both++;
      chk(q_data == pat(eaddr(exp_pop)), tag, q_data, pat(eaddr(exp_pop)));
      exp_pop = exp_pop + 16'd1;
      pops++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!q_valid, "R10 reset q_valid", q_valid, 0);
    chk(!mem_req, "R10 reset mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    repeat (40) step(0, 0, 0, 0);
    chk(!mem_req, "R5 no fetch when full", mem_req, 0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (!q_valid) break;
      step(1, 0, 0, 1);
      n++;
    end
    chk(n == 6, "R1 fill level", n, 6);

    repeat (20) step(1, 0, 0, 1);
    chk(!mem_req && !q_valid, "R6 busy keeps bus idle", {mem_req, q_valid}, 0);

    force_lat = 3;
    for (int i = 0; i < 10 && !mem_req; i++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk(mem_req, "R7 fetch in flight before flush", mem_req, 1);
    step(0, 1, 16'h0100, 0);
    chk(!q_valid, "R7 empty after flush", q_valid, 0);
    force_lat = -1;
    repeat (30) step(0, 0, 0, 1);
    chk(exp_pop > 16'h0100, "R7 refetch from new pointer", exp_pop, 16'h0101);

    step(0, 1, 16'hFFFD, 0);
    repeat (30) step(0, 0, 0, 0);
    pops = 0;
    repeat (8) step(1, 0, 0, 1);
    chk(pops == 6 && exp_pop == 16'h0003, "R3 pointer wrap", exp_pop, 16'h0003);

    both = 0;
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) == 0, ($urandom % 50) == 0, 16'($urandom), ($urandom % 3) != 0);
    chk(both > 0, "R9 simultaneous pop and fill seen", both, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule